// File: doc/BRIEF.md
# Per-Period Power Accumulator Bank

This block sits between a sample filter and the arithmetic that derives rms values, real power, apparent power and power factor for one phase of a power line. It takes paired voltage and current samples, each 12 bits wide in offset-binary code. It turns them into signed values and keeps three running sums: voltage squared, voltage times current, and current squared. Each sum is taken over exactly one cycle of the line voltage.

A line cycle starts on a rising zero crossing of the voltage. At that point the sums of the cycle just ended are copied into output registers, together with the count of samples they cover. A single-cycle `done` pulse marks the copy. The accumulators then restart with the crossing sample as the first term of the new cycle. Downstream logic divides by the count and takes square roots. Because the window follows the signal's own period, a drifting line frequency does not smear the results.

A small sequencer controls the accumulators. It has three states. `ST_SEEK` waits after reset for the first crossing. `ST_RUN` accumulates. `ST_SAT` is entered when the count reaches its ceiling and ignores further samples. The transitions are:
- T_ARM: `ST_SEEK` to `ST_RUN` on the first crossing.
- T_WRAP: `ST_RUN` to `ST_RUN` on a crossing, which snapshots the sums and restarts them.
- T_FULL: `ST_RUN` to `ST_SAT` when the count reaches the ceiling.
- T_RESUME: `ST_SAT` to `ST_RUN` on a crossing, which snapshots the sums and restarts them.

Top module: `pwr_accum_bank`

## Requirements
- R1: A raw sample x (0..4095) is treated as the signed value x - 2048. The conversion inverts bit 11 of the raw code. Raw 2048 is zero, raw 0 is -2048 and raw 4095 is +2047.
- R2: A crossing is an accepted sample whose raw voltage bit 11 is 1 (value zero or positive), where the previous accepted sample had raw voltage bit 11 equal to 0 (negative).
- R3: `sum_vv`, `sum_vi` and `sum_ii` are 32-bit two's-complement values (2*12 + 8 bits). They never overflow, so `sum_vv` and `sum_ii` are never negative.
- R4: Each snapshot sums the products of the samples from one crossing sample, inclusive, up to the next crossing sample, exclusive.
- R5: `n_count` equals the number of samples summed in the snapshot.
- R6: `done` is high for exactly one cycle. That cycle is the one after the clock edge that accepted the closing crossing sample. The outputs take their new values in that same cycle and hold them until the next `done`.
- R7: After reset, samples before the first crossing are not summed. The first crossing produces no `done`.
- R8: The count stops at 255. Samples after the 255th in a period leave the sums unchanged, but they are still watched for the next crossing.
- R9: While reset is low, and after it is released, `done` is 0 and all sums and `n_count` are 0 until the first snapshot.
- R10: A cycle with `smp_valid` low is ignored. It adds nothing and cannot form or break a crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample pair present this cycle |
| v_raw | input | 12 | Voltage sample, offset binary |
| i_raw | input | 12 | Current sample, offset binary |
| done | output | 1 | One-cycle pulse: snapshot updated |
| sum_vv | output | 32 | Sum of voltage squared, last period |
| sum_vi | output | 32 | Sum of voltage times current, last period |
| sum_ii | output | 32 | Sum of current squared, last period |
| n_count | output | 8 | Samples in last period |

## Verification
The assertions rely on `v_raw` being stable on every cycle in which `smp_valid` is high. They also assume a reset is applied before the first clock edge, so that the hold check has a defined starting value. The stimulus drives every sample on the falling edge and holds it through the next rising edge. It starts with reset low from time zero. It also changes the raw inputs freely while `smp_valid` is low, which exercises R10 without breaking those assumptions. Back-to-back crossings cannot occur, because a crossing needs a negative sample just before it. The single-pulse check on `done` depends on that fact.

// File: rtl/pwr_accum_pkg.sv
package pwr_accum_pkg;

    typedef enum logic [1:0] {
        ST_SEEK = 2'd0,
        ST_RUN  = 2'd1,
        ST_SAT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic add;
        logic restart;
    } mac_ctl_t;

endpackage

// File: rtl/pwr_ob2tc.sv
module pwr_ob2tc #(
    parameter int W = 12
) (
    input  logic [W-1:0]        raw,
    output logic signed [W-1:0] tc
);
    // R1: offset binary to two's complement by flipping the top bit
    assign tc = {~raw[W-1], raw[W-2:0]};
endmodule

// File: rtl/pwr_zc_detect.sv
module pwr_zc_detect #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic signed [W-1:0] v_tc,
    output logic                boundary
);
    logic prev_neg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_neg <= 1'b0;
        end else if (valid) begin
            prev_neg <= v_tc[W-1];
        end
    end

    // R2: previous accepted sample negative, current zero or positive
    assign boundary = valid && prev_neg && !v_tc[W-1];
endmodule

// File: rtl/pwr_mac.sv
module pwr_mac
    import pwr_accum_pkg::*;
#(
    parameter int W     = 12,
    parameter int ACC_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  mac_ctl_t                ctl,
    input  logic signed [W-1:0]     a,
    input  logic signed [W-1:0]     b,
    output logic signed [ACC_W-1:0] acc
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext;

    assign prod     = a * b;
    assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (ctl.restart) begin
            acc <= prod_ext;
        end else if (ctl.add) begin
            acc <= acc + prod_ext;
        end
    end
endmodule

// File: rtl/pwr_period_seq.sv
module pwr_period_seq
    import pwr_accum_pkg::*;
#(
    parameter int N_MAX = 255,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             boundary,
    output mac_ctl_t         ctl,
    output logic             snap,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(N_MAX - 1);

    seq_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SEEK;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt         = state;
        ctl.add     = 1'b0;
        ctl.restart = 1'b0;
        snap        = 1'b0;
        unique case (state)
            ST_SEEK: begin
                if (boundary) begin          // T_ARM
                    ctl.restart = 1'b1;
                    nxt         = ST_RUN;
                end
            end
            ST_RUN: begin
                if (boundary) begin          // T_WRAP
                    snap        = 1'b1;
                    ctl.restart = 1'b1;
                end else if (valid) begin
                    ctl.add = 1'b1;
                    if (cnt == CNT_LAST) begin
                        nxt = ST_SAT;        // T_FULL
                    end
                end
            end
            ST_SAT: begin
                if (boundary) begin          // T_RESUME
                    snap        = 1'b1;
                    ctl.restart = 1'b1;
                    nxt         = ST_RUN;
                end
            end
            default: nxt = ST_SEEK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ctl.restart) begin
            cnt <= CNT_W'(1);
        end else if (ctl.add) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/pwr_accum_bank.sv
module pwr_accum_bank
    import pwr_accum_pkg::*;
#(
    parameter  int SMP_W = 12,
    parameter  int N_MAX = 255,
    localparam int CNT_W = $clog2(N_MAX + 1),
    localparam int ACC_W = 2 * SMP_W + CNT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [SMP_W-1:0]        v_raw,
    input  logic [SMP_W-1:0]        i_raw,
    output logic                    done,
    output logic signed [ACC_W-1:0] sum_vv,
    output logic signed [ACC_W-1:0] sum_vi,
    output logic signed [ACC_W-1:0] sum_ii,
    output logic [CNT_W-1:0]        n_count
);
    localparam int N_CH  = 2;
    localparam int N_MAC = 3;

    logic [SMP_W-1:0]        raw_ch [N_CH];
    logic signed [SMP_W-1:0] tc_ch  [N_CH];
    logic signed [SMP_W-1:0] op_a   [N_MAC];
    logic signed [SMP_W-1:0] op_b   [N_MAC];
    logic signed [ACC_W-1:0] acc    [N_MAC];

    logic             boundary;
    logic             snap;
    logic [CNT_W-1:0] cnt;
    mac_ctl_t         ctl;

    assign raw_ch[0] = v_raw;
    assign raw_ch[1] = i_raw;

    for (genvar c = 0; c < N_CH; c++) begin : g_conv
        pwr_ob2tc #(.W(SMP_W)) conv_i (
            .raw (raw_ch[c]),
            .tc  (tc_ch[c])
        );
    end

    pwr_zc_detect #(.W(SMP_W)) zc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (smp_valid),
        .v_tc     (tc_ch[0]),
        .boundary (boundary)
    );

    pwr_period_seq #(.N_MAX(N_MAX), .CNT_W(CNT_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (smp_valid),
        .boundary (boundary),
        .ctl      (ctl),
        .snap     (snap),
        .cnt      (cnt)
    );

    // operand pairs: v*v, v*i, i*i
    assign op_a[0] = tc_ch[0];
    assign op_b[0] = tc_ch[0];
    assign op_a[1] = tc_ch[0];
    assign op_b[1] = tc_ch[1];
    assign op_a[2] = tc_ch[1];
    assign op_b[2] = tc_ch[1];

    for (genvar m = 0; m < N_MAC; m++) begin : g_mac
        pwr_mac #(.W(SMP_W), .ACC_W(ACC_W)) mac_i (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl),
            .a     (op_a[m]),
            .b     (op_b[m]),
            .acc   (acc[m])
        );
    end

    // snapshot taken on the same edge that restarts the accumulators
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            sum_vv  <= '0;
            sum_vi  <= '0;
            sum_ii  <= '0;
            n_count <= '0;
        end else begin
            done <= snap;
            if (snap) begin
                sum_vv  <= acc[0];
                sum_vi  <= acc[1];
                sum_ii  <= acc[2];
                n_count <= cnt;
            end
        end
    end
endmodule

// File: rtl/pwr_accum_bank_chk.sv
module pwr_accum_bank_chk #(
    parameter int SMP_W = 12,
    parameter int N_MAX = 255,
    parameter int CNT_W = 8,
    parameter int ACC_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    smp_valid,
    input logic [SMP_W-1:0]        v_raw,
    input logic                    done,
    input logic signed [ACC_W-1:0] sum_vv,
    input logic signed [ACC_W-1:0] sum_vi,
    input logic signed [ACC_W-1:0] sum_ii,
    input logic [CNT_W-1:0]        n_count
);
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(sum_vv) && $stable(sum_vi) && $stable(sum_ii) && $stable(n_count)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!sum_vv[ACC_W-1] && !sum_ii[ACC_W-1]));

    p_count_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (n_count >= CNT_W'(1) && int'(n_count) <= N_MAX));

    p_crossing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(smp_valid) && $past(v_raw[SMP_W-1])));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !done);
endmodule

bind pwr_accum_bank pwr_accum_bank_chk #(
    .SMP_W (SMP_W),
    .N_MAX (N_MAX),
    .CNT_W (CNT_W),
    .ACC_W (ACC_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .v_raw     (v_raw),
    .done      (done),
    .sum_vv    (sum_vv),
    .sum_vi    (sum_vi),
    .sum_ii    (sum_ii),
    .n_count   (n_count)
);

// File: tb/pwr_accum_bank_tb_top.sv
module pwr_accum_bank_tb_top;
    localparam int SMP_W = 12;
    localparam int N_MAX = 255;
    localparam int CNT_W = 8;
    localparam int ACC_W = 32;
    localparam int N_VEC = 20;

    // {v_raw, i_raw, idle cycles after}
    localparam logic [27:0] VEC [N_VEC] = '{
        {12'd1000, 12'd2000, 4'd1},
        {12'd3000, 12'd2100, 4'd0},
        {12'd3500, 12'd1800, 4'd2},
        {12'd1500, 12'd900,  4'd0},
        {12'd2048, 12'd4095, 4'd1},
        {12'd2500, 12'd10,   4'd0},
        {12'd100,  12'd3000, 4'd3},
        {12'd0,    12'd0,    4'd0},
        {12'd4095, 12'd4095, 4'd0},
        {12'd2047, 12'd2048, 4'd1},
        {12'd2048, 12'd2048, 4'd0},
        {12'd2047, 12'd1,    4'd0},
        {12'd2049, 12'd4000, 4'd2},
        {12'd3000, 12'd500,  4'd0},
        {12'd3900, 12'd3333, 4'd1},
        {12'd1200, 12'd700,  4'd0},
        {12'd800,  12'd222,  4'd0},
        {12'd2600, 12'd2600, 4'd1},
        {12'd2046, 12'd3,    4'd0},
        {12'd2100, 12'd1111, 4'd0}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    smp_valid = 1'b0;
    logic [SMP_W-1:0]        v_raw = '0;
    logic [SMP_W-1:0]        i_raw = '0;
    logic                    done;
    logic signed [ACC_W-1:0] sum_vv, sum_vi, sum_ii;
    logic [CNT_W-1:0]        n_count;

    int n_chk = 0;
    int n_bad = 0;

    longint m_vv, m_vi, m_ii;
    int     m_n;
    bit     m_armed, m_prev_neg;

    always #4 clk = ~clk;

    pwr_accum_bank dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .v_raw     (v_raw),
        .i_raw     (i_raw),
        .done      (done),
        .sum_vv    (sum_vv),
        .sum_vi    (sum_vi),
        .sum_ii    (sum_ii),
        .n_count   (n_count)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_vv = 0; m_vi = 0; m_ii = 0; m_n = 0;
        m_armed = 0; m_prev_neg = 0;
    endtask

    task automatic check_snap(input longint evv, input longint evi, input longint eii, input int en);
        chk(longint'(sum_vv) == evv, "R4 sum_vv", longint'(sum_vv), evv);
        chk(longint'(sum_vi) == evi, "R4 sum_vi", longint'(sum_vi), evi);
        chk(longint'(sum_ii) == eii, "R3 sum_ii", longint'(sum_ii), eii);
        chk(int'(n_count) == en, "R5 n_count", longint'(n_count), longint'(en));
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic send(input logic [11:0] v, input logic [11:0] i);
        int sv, si;
        bit bnd, exp_done;
        longint evv, evi, eii;
        int en;
        sv = int'(v) - 2048;
        si = int'(i) - 2048;
        bnd = m_prev_neg && (sv >= 0);
        exp_done = bnd && m_armed;
        evv = m_vv; evi = m_vi; eii = m_ii; en = m_n;
        if (bnd) begin
            m_armed = 1;
            m_vv = longint'(sv * sv); m_vi = longint'(sv * si); m_ii = longint'(si * si);
            m_n = 1;
        end else if (m_armed && m_n < N_MAX) begin
            m_vv += longint'(sv * sv); m_vi += longint'(sv * si); m_ii += longint'(si * si);
            m_n++;
        end
        m_prev_neg = (sv < 0);
        smp_valid = 1'b1;
        v_raw = v;
        i_raw = i;
        @(negedge clk);
        chk(done == exp_done, "R6 R7 done", longint'(done), longint'(exp_done));
        if (exp_done) check_snap(evv, evi, eii, en);
    endtask

    // R10: idle cycles with garbage on the sample inputs
    task automatic idle(input int k);
        smp_valid = 1'b0;
        for (int c = 0; c < k; c++) begin
            v_raw = (c % 2 == 0) ? 12'd0 : 12'd4095;
            i_raw = 12'd4095;
            @(negedge clk);
            chk(done == 1'b0, "R10 idle done", longint'(done), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && sum_vv == 0 && n_count == 0, "R9 in reset", longint'(sum_vv), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && sum_vi == 0 && sum_ii == 0, "R9 after release", longint'(sum_vi), 0);

        // R2 R4 R5 R6 R7: table walk
        for (int k = 0; k < N_VEC; k++) begin
            send(VEC[k][27:16], VEC[k][15:4]);
            idle(int'(VEC[k][3:0]));
        end

        // R1: known signed values, explicit expectations
        send(12'd0, 12'd0);
        send(12'd2053, 12'd2045);   // +5, -3 (crossing)
        send(12'd2041, 12'd2050);   // -7, +2
        idle(1);
        send(12'd2048, 12'd2048);   // crossing closes: vv 74, vi -29, ii 13, N 2
        chk(longint'(sum_vv) == 74 && longint'(sum_vi) == -29 && longint'(sum_ii) == 13,
            "R1 converted sums", longint'(sum_vi), -29);
        chk(n_count == 8'd2, "R1 count", longint'(n_count), 2);

        // R8 R3: saturation with extreme magnitudes
        send(12'd0, 12'd0);
        send(12'd4095, 12'd4095);
        for (int k = 0; k < 299; k++) send(12'd0, 12'd0);
        send(12'd2048, 12'd2048);
        chk(n_count == 8'd255, "R8 saturated count", longint'(n_count), 255);
        chk(!sum_vv[ACC_W-1], "R3 no overflow", longint'(sum_vv), m_vv);

        // R9 R7: reset mid-period, first crossing after it gives no done
        send(12'd100, 12'd100);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        chk(sum_vv == 0 && n_count == 0 && done == 0, "R9 mid reset", longint'(sum_vv), 0);
        send(12'd100, 12'd100);
        send(12'd3000, 12'd3000);   // first crossing: no done
        send(12'd3100, 12'd1000);
        send(12'd10, 12'd20);
        send(12'd2048, 12'd4095);   // done with N 3
        chk(n_count == 8'd3, "R7 count after rearm", longint'(n_count), 3);
        idle(2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule